// File: doc/BRIEF.md
# QPSK Costas Carrier Recovery

This block takes real 12-bit samples of a QPSK signal that has been bandpass undersampled to a low digital IF and removes the carrier coherently. The design assumes a 40 MHz sample clock. A 70 MHz carrier then folds down to 10 MHz. A phase-accumulator oscillator generates a quadrature pair of local carriers from a table that the design computes itself. The pair drives an in-phase mixer and a quadrature mixer. Each mixer output is smoothed by a short boxcar average, and the two smoothed arms are the baseband outputs.

A sign-based (rectangular) phase detector compares the two arms. A proportional-plus-integral filter, with gains set by shifts, turns the detector output into a correction of the oscillator's control word. A slow copy of the detector output feeds a two-state lock machine. The machine raises a lock flag once the error has stayed small for a long run of samples. The loop settles on any one of four equilibria spaced 90 degrees apart, so the recovered constellation can be rotated by a multiple of 90 degrees. A later stage must resolve that rotation, for example by differential decoding.

Lock machine states and transitions:
- SEEK: counts consecutive quiet samples.
- TRACK: lock is high.
- SETTLE (SEEK to TRACK): taken on the 1024th consecutive quiet sample.
- SLIP (TRACK to SEEK): taken on any sample that is not quiet.

Top module: `costas_qpsk_recovery`

## Requirements
- R1: A 32-bit phase accumulator advances each sample by the control word, modulo 2^32. The local frequency is word·fs/2^32, and the nominal word 2^30 places the oscillator at fs/4 (10 MHz at 40 MHz).
- R2: The oscillator reads a 64-entry table indexed by the top 6 accumulator bits p. With h = p mod 32 and m = floor(4·h·(32−h)·511/1024), entry p is m for p < 32 and −m otherwise. The sine output is entry p and the cosine output is entry (p+16) mod 64.
- R3: On each clock the mixers register I = (x·cos) >>> 9 and Q = (x·(−sin)) >>> 9, where x is the signed input sample and the shifts are arithmetic (floor).
- R4: Each arm keeps the sum of its last 8 registered mixer values, updated one clock after the mixer register. The arm output is that sum >>> 3, so an input image at twice the IF cancels.
- R5: The phase error is e = s(I)·Q − s(Q)·I on the arm outputs, where s(v) = −1 if v < 0 and +1 otherwise.
- R6: The control word is 2^30 + acc_int + (e <<< 14), and each sample acc_int grows by e <<< 7.
- R7: The lock error register is updated as f ← f + ((e − f) >>> 5), starting from zero.
- R8: A sample is quiet when |f| < 64. Lock rises after 1024 consecutive quiet samples and falls on the first sample that is not quiet.
- R9: Starting from reset, the loop reaches lock within 8000 samples for a constant-symbol input at 10 MHz ± 80 kHz with an amplitude of 1000.
- R10: A 90-degree step in the input symbol phase rotates the locked baseband output by 90 degrees, so (I, Q) becomes (−Q, I), and the loop returns to lock without a cycle slip.
- R11: While reset is asserted the accumulator, mixers, sums, integrator and lock error are zero, the machine is in SEEK, and lock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one input sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_in | input | 12 | Two's complement IF sample |
| bb_i | output | 13 | Filtered in-phase arm, signed |
| bb_q | output | 13 | Filtered quadrature arm, signed |
| lock | output | 1 | High while the lock machine is in TRACK |

## Verification
The bench drives carriers at both ends of the ±80 kHz offset range. A loop with the wrong correction sign, or with a truncated integrator, would then run away or sit off frequency and never raise lock. It changes the symbol by a quarter turn once the loop is locked. A detector with a wrong sign convention would turn that into a slip or the wrong rotation rather than a clean (−Q, I) move. A 30-degree phase kick then forces lock to drop and return. A lock machine that never leaves TRACK, or that counts the run incorrectly, would show up at that kick and at every cycle of the exact comparison against the bench model.

// File: rtl/costas_pkg.sv
package costas_pkg;

    typedef enum logic [0:0] {
        SEEK  = 1'b0,
        TRACK = 1'b1
    } lock_state_t;

    // Parabolic half-wave magnitude for index h within a half period.
    function automatic int lut_mag(input int h, input int half, input int amp);
        return (4 * h * (half - h) * amp) / (half * half);
    endfunction

endpackage

// File: rtl/costas_nco.sv
module costas_nco #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 6,
    parameter int LO_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-1:0]        fcw,
    output logic signed [LO_W-1:0]  lo_cos,
    output logic signed [LO_W-1:0]  lo_sin
);
    localparam int ENTRIES = 1 << PH_W;
    localparam int HALF    = ENTRIES / 2;
    localparam int QTR     = ENTRIES / 4;
    localparam int AMP     = (1 << (LO_W - 1)) - 1;

    logic [ACC_W-1:0]       acc_q;
    logic [PH_W-1:0]        ph_sin, ph_cos;
    logic signed [LO_W-1:0] wave [ENTRIES];

    // Table computed at elaboration: one entry per phase step
    for (genvar k = 0; k < ENTRIES; k++) begin : g_wave
        localparam int MAG = costas_pkg::lut_mag(k % HALF, HALF, AMP);
        localparam int VAL = (k >= HALF) ? -MAG : MAG;
        assign wave[k] = LO_W'(VAL);
    end

    assign ph_sin = acc_q[ACC_W-1 -: PH_W];
    assign ph_cos = ph_sin + PH_W'(QTR);
    assign lo_sin = wave[ph_sin];
    assign lo_cos = wave[ph_cos];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + fcw;
    end

    logic [LO_W-1:0] mag_s, mag_c;
    assign mag_s = lo_sin[LO_W-1] ? LO_W'(-lo_sin) : LO_W'(lo_sin);
    assign mag_c = lo_cos[LO_W-1] ? LO_W'(-lo_cos) : LO_W'(lo_cos);

    // R2: the quadrature pair never collapses together
    a_r2_quadrature: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(mag_s) + 32'(mag_c)) >= 32'(AMP - 1));

endmodule

// File: rtl/costas_arm.sv
module costas_arm #(
    parameter int SAMPLE_W = 12,
    parameter int LO_W     = 10,
    parameter int TAPS_LOG = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic signed [SAMPLE_W-1:0]  sample,
    input  logic signed [LO_W-1:0]      lo,
    output logic signed [SAMPLE_W:0]    bb
);
    localparam int TAPS   = 1 << TAPS_LOG;
    localparam int PROD_W = SAMPLE_W + LO_W;
    localparam int MIX_W  = SAMPLE_W + 1;
    localparam int SUM_W  = MIX_W + TAPS_LOG;

    logic signed [PROD_W-1:0] prod, prod_sh;
    logic signed [MIX_W-1:0]  mix_q;
    logic signed [MIX_W-1:0]  win [TAPS];
    logic signed [SUM_W-1:0]  sum_q, sum_sh;

    assign prod    = PROD_W'(sample) * PROD_W'(lo);
    assign prod_sh = prod >>> (LO_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mix_q <= '0;
            sum_q <= '0;
            for (int t = 0; t < TAPS; t++) win[t] <= '0;
        end else begin
            mix_q  <= MIX_W'(prod_sh);
            sum_q  <= sum_q + SUM_W'(mix_q) - SUM_W'(win[TAPS-1]);
            win[0] <= mix_q;
            for (int t = 1; t < TAPS; t++) win[t] <= win[t-1];
        end
    end

    assign sum_sh = sum_q >>> TAPS_LOG;
    assign bb     = MIX_W'(sum_sh);

    // R3: a zero sample yields a zero mixer product one clock later
    a_r3_silent_in: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sample) == '0) |-> (mix_q == '0));

    // R4: the averaged arm stays within the input range
    a_r4_avg_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bb) <= (1 << (SAMPLE_W - 1))) && (int'(bb) >= -(1 << (SAMPLE_W - 1))));

endmodule

// File: rtl/costas_loop_ctl.sv
module costas_loop_ctl #(
    parameter int ARM_W  = 13,
    parameter int ACC_W  = 32,
    parameter int KP_SH  = 14,
    parameter int KI_SH  = 7,
    parameter int ERR_SH = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [ARM_W-1:0]    arm_i,
    input  logic signed [ARM_W-1:0]    arm_q,
    output logic [ACC_W-1:0]           fcw,
    output logic signed [ARM_W+2:0]    err_lp
);
    localparam int PD_W   = ARM_W + 2;
    localparam int ERR_W  = ARM_W + 3;
    localparam int DIFF_W = ERR_W + 1;
    localparam logic [ACC_W-1:0] NOM_FCW = ACC_W'(1) << (ACC_W - 2);

    logic signed [PD_W-1:0]   ie, qe, t1, t2, pd;
    logic signed [ACC_W-1:0]  pd_wide, integ_q;
    logic signed [ERR_W-1:0]  err_q;
    logic signed [DIFF_W-1:0] diff, diff_sh;

    // Sign-based detector: each arm weighted by the other's polarity
    assign ie      = PD_W'(arm_i);
    assign qe      = PD_W'(arm_q);
    assign t1      = arm_i[ARM_W-1] ? -qe : qe;
    assign t2      = arm_q[ARM_W-1] ? -ie : ie;
    assign pd      = t1 - t2;
    assign pd_wide = ACC_W'(pd);

    assign fcw = NOM_FCW + ACC_W'(integ_q) + ACC_W'(pd_wide <<< KP_SH);

    assign diff    = DIFF_W'(pd) - DIFF_W'(err_q);
    assign diff_sh = diff >>> ERR_SH;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            integ_q <= '0;
            err_q   <= '0;
        end else begin
            integ_q <= integ_q + (pd_wide <<< KI_SH);
            err_q   <= err_q + ERR_W'(diff_sh);
        end
    end

    assign err_lp = err_q;

    // R6: a positive error never lowers the integrator
    a_r6_integ_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pd) > 0) |-> (integ_q >= $past(integ_q)));

    // R7: the lock error never moves away from the detector output
    a_r7_err_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pd) > PD_W'($past(err_q))) |-> (err_q >= $past(err_q)));

endmodule

// File: rtl/costas_qpsk_recovery.sv
module costas_qpsk_recovery #(
    parameter int SAMPLE_W    = 12,
    parameter int ACC_W       = 32,
    parameter int PH_W        = 6,
    parameter int LO_W        = 10,
    parameter int TAPS_LOG    = 3,
    parameter int KP_SH       = 14,
    parameter int KI_SH       = 7,
    parameter int ERR_SH      = 5,
    parameter int LOCK_THRESH = 64,
    parameter int LOCK_LEN    = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] adc_in,
    output logic signed [SAMPLE_W:0]   bb_i,
    output logic signed [SAMPLE_W:0]   bb_q,
    output logic                       lock
);
    import costas_pkg::*;

    localparam int ARM_W = SAMPLE_W + 1;
    localparam int ERR_W = ARM_W + 3;
    localparam int CNT_W = $clog2(LOCK_LEN + 1);

    logic [ACC_W-1:0]        fcw;
    logic signed [LO_W-1:0]  lo_cos, lo_sin;
    logic signed [LO_W-1:0]  lo_arm  [2];
    logic signed [ARM_W-1:0] arm_out [2];
    logic signed [ERR_W-1:0] err_lp, err_mag;
    logic                    quiet;
    lock_state_t             state_q, state_d;
    logic [CNT_W-1:0]        cnt_q, cnt_d;

    costas_nco #(.ACC_W(ACC_W), .PH_W(PH_W), .LO_W(LO_W)) u_nco (
        .clk(clk), .rst_n(rst_n), .fcw(fcw), .lo_cos(lo_cos), .lo_sin(lo_sin)
    );

    assign lo_arm[0] = lo_cos;
    assign lo_arm[1] = -lo_sin;

    for (genvar a = 0; a < 2; a++) begin : g_arm
        costas_arm #(.SAMPLE_W(SAMPLE_W), .LO_W(LO_W), .TAPS_LOG(TAPS_LOG)) u_arm (
            .clk(clk), .rst_n(rst_n), .sample(adc_in), .lo(lo_arm[a]), .bb(arm_out[a])
        );
    end

    assign bb_i = arm_out[0];
    assign bb_q = arm_out[1];

    costas_loop_ctl #(
        .ARM_W(ARM_W), .ACC_W(ACC_W), .KP_SH(KP_SH), .KI_SH(KI_SH), .ERR_SH(ERR_SH)
    ) u_loop (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_out[0]), .arm_q(arm_out[1]),
        .fcw(fcw), .err_lp(err_lp)
    );

    assign err_mag = err_lp[ERR_W-1] ? -err_lp : err_lp;
    assign quiet   = err_mag < ERR_W'(LOCK_THRESH);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEEK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: SETTLE and SLIP transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            SEEK: begin
                if (quiet) begin
                    if (cnt_q == CNT_W'(LOCK_LEN - 1)) state_d = TRACK;
                    else                               cnt_d   = cnt_q + 1'b1;
                end
            end
            TRACK: begin
                if (!quiet) state_d = SEEK;
            end
            default: state_d = SEEK;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            TRACK:   lock = 1'b1;
            default: lock = 1'b0;
        endcase
    end

    // R8: a noisy sample in TRACK always ends the lock
    a_r8_slip: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !quiet) |=> !lock);

    // R8: lock only rises after a quiet sample
    a_r8_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(quiet));

endmodule

// File: tb/costas_qpsk_recovery_test.sv
module costas_qpsk_recovery_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n;
    logic signed [11:0] adc_in;
    wire  signed [12:0] bb_i, bb_q;
    wire                lock;

    int  n_cmp = 0, n_bad = 0, cyc = 0, n_smp = 0, sym = 0;
    real off_hz = 0.0, step_rad = 0.0;
    bit  zero_in = 0;
    localparam real PI = 3.14159265358979;

    costas_qpsk_recovery uut (
        .clk(clk), .rst_n(rst_n), .adc_in(adc_in),
        .bb_i(bb_i), .bb_q(bb_q), .lock(lock)
    );

    // Reference model state
    bit [31:0] m_acc;
    int m_mi, m_mq, m_si, m_sq, m_integ, m_err, m_state, m_cnt;
    int m_wi [8];
    int m_wq [8];

    function automatic int tbl(int p); // R2 table
        int h, m;
        h = p % 32;
        m = (4 * h * (32 - h) * 511) / 1024;
        return (p >= 32) ? -m : m;
    endfunction

    function automatic int sg(int v);
        return (v < 0) ? -1 : 1;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int ai, aq, pd, x, p, lc, ls, nmi, nmq;
        bit [31:0] fcw;
        bit quiet;
        if (!rst_n) begin // R11
            m_acc = 0; m_mi = 0; m_mq = 0; m_si = 0; m_sq = 0;
            m_integ = 0; m_err = 0; m_state = 0; m_cnt = 0;
            for (int k = 0; k < 8; k++) begin m_wi[k] = 0; m_wq[k] = 0; end
        end else begin
            ai = m_si >>> 3; aq = m_sq >>> 3;
            pd = sg(ai) * aq - sg(aq) * ai;                  // R5
            fcw = 32'h4000_0000 + m_integ + (pd <<< 14);     // R6
            p  = int'(m_acc[31:26]);
            lc = tbl((p + 16) % 64); ls = tbl(p);
            x  = int'(adc_in);
            nmi = (x * lc) >>> 9;                            // R3
            nmq = (x * (-ls)) >>> 9;
            m_si = m_si + m_mi - m_wi[7];                    // R4
            m_sq = m_sq + m_mq - m_wq[7];
            for (int k = 7; k > 0; k--) begin m_wi[k] = m_wi[k-1]; m_wq[k] = m_wq[k-1]; end
            m_wi[0] = m_mi; m_wq[0] = m_mq;
            m_mi = nmi; m_mq = nmq;
            quiet = ((m_err < 0) ? -m_err : m_err) < 64;     // R8
            if (m_state == 0) begin
                if (quiet) begin
                    if (m_cnt == 1023) begin m_state = 1; m_cnt = 0; end
                    else m_cnt++;
                end else m_cnt = 0;
            end else begin
                m_cnt = 0;
                if (!quiet) m_state = 0;
            end
            m_err = m_err + ((pd - m_err) >>> 5);            // R7
            m_integ = m_integ + (pd <<< 7);
            m_acc = m_acc + fcw;                             // R1
        end
    end

    // Cycle-by-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        check(int'(bb_i) == (m_si >>> 3), "R4", "bb_i", int'(bb_i), m_si >>> 3);
        check(int'(bb_q) == (m_sq >>> 3), "R4", "bb_q", int'(bb_q), m_sq >>> 3);
        check(int'(lock) == m_state, "R8", "lock", int'(lock), m_state);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(0, "WD", "watchdog", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic drive(int cycles);
        repeat (cycles) begin
            real ph, c;
            @(negedge clk);
            ph = 2.0 * PI * (0.25 + off_hz / 40.0e6) * n_smp + (2 * sym + 1) * PI / 4.0 + step_rad;
            c  = 1000.0 * $cos(ph);
            adc_in = zero_in ? 12'sd0 : 12'($rtoi(c + ((c >= 0.0) ? 0.5 : -0.5)));
            n_smp++;
        end
    endtask

    initial begin
        int i0, q0, i1, q1;
        bit dropped;
        rst_n = 1'b0; adc_in = '0;
        repeat (4) @(negedge clk);
        check(bb_i == 0 && bb_q == 0, "R11", "reset arms", int'(bb_i), 0);
        check(lock == 1'b0, "R11", "reset lock", int'(lock), 0);
        rst_n = 1'b1;

        // R9: upper offset pull-in, R1 nominal frequency plus correction
        off_hz = 80.0e3; sym = 0;
        drive(8000);
        check(lock == 1'b1, "R9", "lock at +80k", int'(lock), 1);
        i0 = int'(bb_i); q0 = int'(bb_q);
        check(i0 * i0 + q0 * q0 > 150 * 150, "R10", "locked magnitude", i0, 150);

        // R10: quarter-turn symbol step rotates the output
        sym = 1;
        drive(400);
        i1 = int'(bb_i); q1 = int'(bb_q);
        check(sg(i1) == -sg(q0), "R10", "rotated I sign", sg(i1), -sg(q0));
        check(sg(q1) == sg(i0), "R10", "rotated Q sign", sg(q1), sg(i0));
        drive(3000);
        check(lock == 1'b1, "R10", "lock after symbol step", int'(lock), 1);

        // R8: a 30 degree phase kick must break lock, then lock returns
        step_rad = PI / 6.0;
        dropped = 0;
        repeat (300) begin
            drive(1);
            if (!lock) dropped = 1;
        end
        check(dropped, "R8", "lock drop on kick", int'(dropped), 1);
        drive(3000);
        check(lock == 1'b1, "R8", "relock after kick", int'(lock), 1);

        // R9: lower offset pull-in from reset
        @(negedge clk); rst_n = 1'b0;
        off_hz = -80.0e3; sym = 2; step_rad = 0.0; n_smp = 0;
        drive(3);
        rst_n = 1'b1;
        drive(8000);
        check(lock == 1'b1, "R9", "lock at -80k", int'(lock), 1);

        // R3: silent input empties both arms
        zero_in = 1;
        drive(40);
        check(bb_i == 0, "R3", "silent I", int'(bb_i), 0);
        check(bb_q == 0, "R3", "silent Q", int'(bb_q), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule